// File: doc/BRIEF.md
# Large-Prime Event Scheduler Ring

This block is one station of a sieving pipeline that serves arithmetic progressions with large intervals. Each progression is held as a pending event: its interval, the next sieve index it hits, and the weight it adds there. The events sit in a circular slot memory indexed by index group, where a group is `LANES` consecutive sieve indices. The pipeline tells the block which group is passing through it. The block then emits, one per clock, the events whose index falls in that group. Each contribution carries the lane (index modulo `LANES`) and the weight.

Once an event has been emitted, its index is moved forward by its interval. The event is written back into the slot that serves its new group. That slot lies ahead of the read position, so the ring holds events in order of increasing index without any sorting logic. A slot holds `WAYS` events. When that slot is full, the event spills into one of up to `SLACK` slots just before it. The read window covers those spill slots, so a spilled event is still emitted on time. If every candidate slot is full, the event is dropped and a sticky overflow flag is set. Events enter the ring through a preload port, which uses the same placement logic.

Top module: `lp_event_ring`

## Requirements
- R1: After reset the ring holds no events, `hit_vld_o` is 0 and `ovf_o` is 0.
- R2: In a cycle where `pre_vld_i` is high, the event is stored and no contribution is emitted; a due event waits and is emitted in a later cycle.
- R3: An event with index a is emitted only while `grp_i` equals a >> log2(LANES). One cycle later `hit_vld_o` is 1, `hit_idx_o` is a, `hit_lane_o` is the low log2(LANES) bits of a, and `hit_wt_o` is the event's stored weight.
- R4: After an event is emitted its index becomes a + interval, and the event is emitted again with that index once its group is presented.
- R5: At most one event is emitted per cycle. Every event due in the presented group is emitted over consecutive cycles. Events not yet due stay stored and are not emitted.
- R6: An event is placed in slot (group mod SLOTS) when a way there is free, otherwise in the nearest of the `SLACK` preceding slots with a free way; placed events are emitted in their group like any other.
- R7: When no candidate slot has a free way, the event is dropped and `ovf_o` becomes 1 and stays 1 until reset.
- R8: Emitting and rescheduling keeps the number of stored events unchanged, and a preload adds one, unless the event is dropped under R7.
- R9: An interval shorter than `LANES` can land in the same group again; the event is then emitted again in that group, at its new index, in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_vld_i | input | 1 | Preload an event this cycle |
| pre_idx_i | input | IDX_W | First sieve index hit by the preloaded event |
| pre_stp_i | input | STEP_W | Interval of the preloaded progression |
| pre_wt_i | input | WT_W | Weight the progression adds at each hit |
| grp_i | input | IDX_W-log2(LANES) | Index group now in the pipeline |
| hit_vld_o | output | 1 | A contribution is present |
| hit_idx_o | output | IDX_W | Sieve index of the contribution |
| hit_lane_o | output | log2(LANES) | Pipeline lane of the contribution |
| hit_wt_o | output | WT_W | Weight to add on that lane |
| ovf_o | output | 1 | Sticky: an event was dropped for lack of room |

## Verification
The assertions assume that `grp_i` never moves backwards and advances by at most one group at a time. They also assume it rests on each group long enough for every due event to leave. In addition, intervals are nonzero, indices do not wrap the `IDX_W` range, and no event is preloaded into a group that has already passed. The directed tests change the group only after the due events have drained, and they use small indices with intervals that keep each rescheduled event within the ring. Each test also starts from a fresh reset, so no stale event from an earlier scenario stays in the ring.

// File: rtl/lp_event_ring.sv
module lp_event_ring #(
  parameter int IDX_W  = 16,
  parameter int STEP_W = 12,
  parameter int WT_W   = 8,
  parameter int LANES  = 4,
  parameter int SLOTS  = 8,
  parameter int WAYS   = 2,
  parameter int SLACK  = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              pre_vld_i,
  input  logic [IDX_W-1:0]                  pre_idx_i,
  input  logic [STEP_W-1:0]                 pre_stp_i,
  input  logic [WT_W-1:0]                   pre_wt_i,
  input  logic [IDX_W-$clog2(LANES)-1:0]    grp_i,
  output logic                              hit_vld_o,
  output logic [IDX_W-1:0]                  hit_idx_o,
  output logic [$clog2(LANES)-1:0]          hit_lane_o,
  output logic [WT_W-1:0]                   hit_wt_o,
  output logic                              ovf_o
);
  localparam int LANE_W = $clog2(LANES);
  localparam int GRP_W  = IDX_W - LANE_W;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int ENT    = SLOTS * WAYS;
  localparam int ENT_W  = $clog2(ENT);
  localparam int WIN    = SLACK + 1;

  logic [ENT-1:0]    vld;
  logic [IDX_W-1:0]  idx [ENT];
  logic [STEP_W-1:0] stp [ENT];
  logic [WT_W-1:0]   wt  [ENT];

  logic [SLOT_W-1:0] rd_slot;
  logic              due_hit;
  logic [ENT_W-1:0]  due_e;
  logic              emit;

  assign rd_slot = grp_i[SLOT_W-1:0];

  always_comb begin
    logic [SLOT_W-1:0] sl;
    logic [ENT_W-1:0]  e;
    due_hit = 1'b0;
    due_e   = '0;
    for (int k = 0; k < WIN; k++) begin
      sl = rd_slot - SLOT_W'(SLACK) + SLOT_W'(k);
      for (int w = 0; w < WAYS; w++) begin
        e = ENT_W'(sl) * ENT_W'(WAYS) + ENT_W'(w);
        if (!due_hit && vld[e] && idx[e][IDX_W-1:LANE_W] == grp_i) begin
          due_hit = 1'b1;
          due_e   = e;
        end
      end
    end
  end

  assign emit = due_hit && !pre_vld_i;

  logic              put_vld;
  logic [IDX_W-1:0]  put_idx;
  logic [STEP_W-1:0] put_stp;
  logic [WT_W-1:0]   put_wt;
  logic [SLOT_W-1:0] put_slot;
  logic              put_ok;
  logic [ENT_W-1:0]  put_e;

  assign put_vld  = pre_vld_i || emit;
  assign put_idx  = pre_vld_i ? pre_idx_i : idx[due_e] + IDX_W'(stp[due_e]);
  assign put_stp  = pre_vld_i ? pre_stp_i : stp[due_e];
  assign put_wt   = pre_vld_i ? pre_wt_i  : wt[due_e];
  assign put_slot = put_idx[LANE_W +: SLOT_W];

  always_comb begin
    logic [SLOT_W-1:0] sl;
    logic [ENT_W-1:0]  e;
    put_ok = 1'b0;
    put_e  = '0;
    for (int k = 0; k < WIN; k++) begin
      sl = put_slot - SLOT_W'(k);
      for (int w = 0; w < WAYS; w++) begin
        e = ENT_W'(sl) * ENT_W'(WAYS) + ENT_W'(w);
        if (!put_ok && (!vld[e] || (emit && e == due_e))) begin
          put_ok = 1'b1;
          put_e  = e;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      ovf_o     <= 1'b0;
      hit_vld_o <= 1'b0;
    end else begin
      if (emit)
        vld[due_e] <= 1'b0;
      if (put_vld && put_ok)
        vld[put_e] <= 1'b1;
      if (put_vld && !put_ok)
        ovf_o <= 1'b1;
      hit_vld_o <= emit;
    end
  end

  always_ff @(posedge clk) begin
    if (put_vld && put_ok) begin
      idx[put_e] <= put_idx;
      stp[put_e] <= put_stp;
      wt[put_e]  <= put_wt;
    end
    if (emit) begin
      hit_idx_o  <= idx[due_e];
      hit_lane_o <= idx[due_e][LANE_W-1:0];
      hit_wt_o   <= wt[due_e];
    end
  end

  logic [ENT_W:0] occ;
  assign occ = (ENT_W+1)'($countones(vld));

  a_r1_empty_after_reset: assert property (@(posedge clk)
    $past(!rst_n) |-> (occ == '0 && !hit_vld_o && !ovf_o));

  a_r2_no_emit_on_preload: assert property (@(posedge clk) disable iff (!rst_n)
    pre_vld_i |=> !hit_vld_o);

  a_r3_emit_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vld_o |-> hit_idx_o[IDX_W-1:LANE_W] == $past(grp_i));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  a_r8_preload_adds: assert property (@(posedge clk) disable iff (!rst_n)
    pre_vld_i |=> (ovf_o || occ == $past(occ) + 1'b1));

  a_r8_emit_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_vld_i && !ovf_o) |=> (ovf_o || occ == $past(occ)));
endmodule

// File: tb/lp_event_ring_tb.sv
module lp_event_ring_tb;
  localparam int IDX_W  = 16;
  localparam int STEP_W = 12;
  localparam int WT_W   = 8;
  localparam int LANE_W = 2;
  localparam int GRP_W  = IDX_W - LANE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pre_vld_i = 1'b0;
  logic [IDX_W-1:0]  pre_idx_i = '0;
  logic [STEP_W-1:0] pre_stp_i = '0;
  logic [WT_W-1:0]   pre_wt_i = '0;
  logic [GRP_W-1:0]  grp_i = '0;
  logic              hit_vld_o;
  logic [IDX_W-1:0]  hit_idx_o;
  logic [LANE_W-1:0] hit_lane_o;
  logic [WT_W-1:0]   hit_wt_o;
  logic              ovf_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  lp_event_ring u_dut (
    .clk(clk), .rst_n(rst_n),
    .pre_vld_i(pre_vld_i), .pre_idx_i(pre_idx_i), .pre_stp_i(pre_stp_i), .pre_wt_i(pre_wt_i),
    .grp_i(grp_i),
    .hit_vld_o(hit_vld_o), .hit_idx_o(hit_idx_o), .hit_lane_o(hit_lane_o), .hit_wt_o(hit_wt_o),
    .ovf_o(ovf_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog (all requirements): actual=%0d cycles expected=completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pre_vld_i = 1'b0;
    grp_i = '0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic preload(input int a, input int p, input int w);
    pre_vld_i = 1'b1;
    pre_idx_i = IDX_W'(a);
    pre_stp_i = STEP_W'(p);
    pre_wt_i  = WT_W'(w);
    step();
    pre_vld_i = 1'b0;
  endtask

  task automatic expect_hit(input string req, input int a, input int w);
    step();
    chk({req, " valid"}, int'(hit_vld_o), 1);
    if (hit_vld_o) begin
      chk({req, " index"}, int'(hit_idx_o), a);
      chk({req, " lane"}, int'(hit_lane_o), a % 4);
      chk({req, " weight"}, int'(hit_wt_o), w);
    end
  endtask

  task automatic expect_none(input string req);
    step();
    chk({req, " idle"}, int'(hit_vld_o), 0);
  endtask

  task automatic collect(input int n, output int cnt, output int mask);
    cnt = 0;
    mask = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (hit_vld_o) begin
        cnt++;
        mask = mask | (1 << hit_lane_o);
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 hit_vld after reset", int'(hit_vld_o), 0);
    chk("R1 ovf after reset", int'(ovf_o), 0);
    expect_none("R1 empty ring");
  endtask

  task automatic t_single();
    do_reset();
    preload(5, 9, 7);
    grp_i = GRP_W'(1);
    expect_hit("R3 first hit", 5, 7);
    expect_none("R5 rescheduled not due");
    grp_i = GRP_W'(2);
    expect_none("R5 group 2 idle");
    grp_i = GRP_W'(3);
    expect_hit("R4 advanced hit", 14, 7);
  endtask

  task automatic t_preload_block();
    int cnt, mask;
    do_reset();
    preload(5, 20, 1);
    grp_i = GRP_W'(1);
    preload(6, 20, 2);
    chk("R2 no emit while preloading", int'(hit_vld_o), 0);
    collect(2, cnt, mask);
    chk("R5 two due events", cnt, 2);
    chk("R5 lanes of due events", mask, 'b0110);
    expect_none("R5 group drained");
  endtask

  task automatic t_short_step();
    do_reset();
    preload(8, 1, 3);
    grp_i = GRP_W'(2);
    for (int i = 0; i < 4; i++)
      expect_hit("R9 same group", 8 + i, 3);
    expect_none("R9 left group");
    grp_i = GRP_W'(3);
    expect_hit("R9 next group", 12, 3);
  endtask

  task automatic t_overflow();
    int cnt, mask;
    do_reset();
    for (int i = 0; i < 4; i++)
      preload(12 + i, 8, i);
    chk("R6 spill without overflow", int'(ovf_o), 0);
    preload(12, 8, 9);
    chk("R7 overflow raised", int'(ovf_o), 1);
    grp_i = GRP_W'(3);
    collect(5, cnt, mask);
    chk("R6 spilled events emitted", cnt, 4);
    chk("R6 spilled lanes", mask, 'hF);
    chk("R7 overflow held", int'(ovf_o), 1);
    grp_i = GRP_W'(4);
    collect(2, cnt, mask);
    chk("R5 group 4 idle", cnt, 0);
    grp_i = GRP_W'(5);
    collect(5, cnt, mask);
    chk("R8 all events kept", cnt, 4);
    chk("R8 lanes kept", mask, 'hF);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_preload_block();
    t_short_step();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule